// File: doc/BRIEF.md
# Interleaved Operand SRAM Loader

The loader fills the operand SRAM of a modular-exponentiation accelerator from system memory. A start strobe latches a byte-aligned base address and a byte length. The block then reads the image one 32-bit word at a time over a request/response read port, from the lowest address upward. Each returned word goes into the SRAM word with the same index. A one-cycle done pulse follows the last word.

The SRAM holds three operands interleaved in stripes of twelve words. Each stripe carries four exponent words, then four modulus words, then four message-data words. The arithmetic engine does not address the SRAM physically. It names an operand and a logical dword index, and the block translates that into the stripe-and-offset location, returning the stored word one cycle later.

A CPU-access select hands the SRAM to the processor. While it is active the loader writes nothing, and a start strobe is ignored.

Top module: `opsram_loader`

## Requirements
- R1: A start accepted while idle, with the CPU-access select low and a non-zero length, raises busy and issues the first read request in the next cycle.
- R2: Read requests go out one at a time, each one cycle long. No new request is issued until the previous response arrives. Request i carries byte address base + 4*i.
- R3: The response to request i is written into SRAM word i.
- R4: The word count is the byte length rounded up to whole 32-bit words, limited to the image size (IMG_WORDS words).
- R5: A zero-length start issues no read and raises done in the following cycle, with busy low.
- R6: done is a single-cycle pulse. It rises in the cycle after the last response is taken, and busy falls in the same cycle. For n words with single-cycle responses, done appears 2*n+1 cycles after the start strobe.
- R7: A start strobe while busy is ignored. The current transfer keeps its base address and word count.
- R8: While the CPU-access select is high, a start is ignored and no SRAM word is written. A response that arrives in that state is dropped, and the target word keeps its old content.
- R9: The lookup returns, one cycle after the request, the SRAM word at physical index 12*(k/4) + (k mod 4) + 4*s, where k is the logical dword index. The operand code s is 0 for exponent, 1 for modulus and 2 for data.
- R10: Operand code 3 on the lookup returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load start strobe |
| cpu_sel | input | 1 | SRAM owned by CPU; blocks loads and writes |
| base_addr | input | AW | Byte base address of the image |
| byte_len | input | LEN_W | Image length in bytes |
| rd_req | output | 1 | Read request, one cycle |
| rd_addr | output | AW | Byte address of the requested word |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Read response word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete pulse |
| lk_sel | input | 2 | Lookup operand: 0 exponent, 1 modulus, 2 data, 3 none |
| lk_idx | input | IDX_W | Lookup logical dword index |
| lk_data | output | 32 | Looked-up SRAM word, one cycle latency |

## Verification
The properties assume that the memory returns at most one response per request, and only while a request is outstanding. The bench memory model meets this by answering every request exactly one cycle after it sees it. Start strobes are driven only as single-cycle pulses away from the clock edge. The byte length is held stable while a strobe is applied, which the zero-length and start-acceptance properties rely on. The bench uses an image of 48 words so that it can sweep every operand and every index after each load.

// File: rtl/opsram_loader.sv
module opsram_loader #(
  parameter int IMG_WORDS = 1536,
  parameter int AW        = 32,
  parameter int LEN_W     = $clog2(IMG_WORDS * 4) + 1,
  parameter int IDX_W     = $clog2((IMG_WORDS / 12) * 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cpu_sel,
  input  logic [AW-1:0]    base_addr,
  input  logic [LEN_W-1:0] byte_len,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_valid,
  input  logic [31:0]      rd_data,
  output logic             busy,
  output logic             done,
  input  logic [1:0]       lk_sel,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [31:0]      lk_data
);
  localparam int WW   = $clog2(IMG_WORDS);
  localparam int OPDW = (IMG_WORDS / 12) * 4;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t             st;
  logic [WW-1:0]   cnt;
  logic [WW:0]     nwords;
  logic [AW-1:0]   base_q;
  logic [31:0]     mem [IMG_WORDS];

  logic [LEN_W:0]  rounded;
  logic [WW:0]     want;
  logic            accept, last, wr_en;
  logic [WW:0]     phys;
  logic            lk_ok;

  assign rounded = ({1'b0, byte_len} + (LEN_W+1)'(3)) >> 2;
  assign want    = (rounded > (LEN_W+1)'(IMG_WORDS)) ? (WW+1)'(IMG_WORDS) : rounded[WW:0];
  assign accept  = start && (st == S_IDLE) && !cpu_sel;
  assign last    = ({1'b0, cnt} == nwords - (WW+1)'(1));
  assign wr_en   = (st == S_WAIT) && rd_valid && !cpu_sel;

  assign rd_req  = (st == S_REQ);
  assign rd_addr = base_q + AW'({cnt, 2'b00});
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      nwords <= '0;
      base_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          base_q <= base_addr;
          cnt    <= '0;
          if (want == '0) done <= 1'b1;
          else begin
            nwords <= want;
            st     <= S_REQ;
          end
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (rd_valid) begin
          if (last) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt + WW'(1);
            st  <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (wr_en) mem[cnt] <= rd_data;

  assign phys = (WW+1)'(3) * (WW+1)'({lk_idx[IDX_W-1:2], 2'b00})
              + (WW+1)'(lk_idx[1:0])
              + (WW+1)'({lk_sel, 2'b00});
  assign lk_ok = (lk_sel != 2'd3) && ({1'b0, lk_idx} < (IDX_W+1)'(OPDW));

  always_ff @(posedge clk) begin
    if (!rst_n) lk_data <= '0;
    else        lk_data <= lk_ok ? mem[phys[WW-1:0]] : 32'd0;
  end
endmodule

module opsram_loader_chk #(
  parameter int AW    = 32,
  parameter int LEN_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cpu_sel,
  input logic [LEN_W-1:0] byte_len,
  input logic             rd_req,
  input logic             busy,
  input logic             done
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req);
  // R8
  sel_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cpu_sel && !busy) |=> (!busy && !done));
  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cpu_sel && !busy && byte_len == '0) |=> (done && !busy && !rd_req));
  // R1
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cpu_sel && !busy && byte_len != '0) |=> (busy && rd_req));
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
endmodule

bind opsram_loader opsram_loader_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cpu_sel(cpu_sel), .byte_len(byte_len),
  .rd_req(rd_req), .busy(busy), .done(done)
);

// File: tb/opsram_loader_tb.sv
module opsram_loader_tb;
  localparam int IMG = 48;
  localparam int AW = 32;
  localparam int LEN_W = $clog2(IMG * 4) + 1;
  localparam int IDX_W = $clog2((IMG / 12) * 4);
  localparam int OPDW = (IMG / 12) * 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cpu_sel = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [LEN_W-1:0] byte_len = '0;
  logic rd_req, rd_valid = 1'b0, busy, done;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data = '0, lk_data;
  logic [1:0] lk_sel = '0;
  logic [IDX_W-1:0] lk_idx = '0;

  int errors = 0, checks = 0, nreq = 0;
  logic [31:0] run_base = '0, salt = '0;
  logic [31:0] model [IMG];
  int ridx = 0;

  always #4 clk = ~clk;

  opsram_loader #(.IMG_WORDS(IMG), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cpu_sel(cpu_sel),
    .base_addr(base_addr), .byte_len(byte_len), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
    .lk_sel(lk_sel), .lk_idx(lk_idx), .lk_data(lk_data));

  function automatic logic [31:0] pat(input logic [31:0] a, input logic [31:0] s);
    return (a * 32'h9E3779B1) ^ s;
  endfunction

  always @(posedge clk) begin
    if (rd_valid && !cpu_sel) model[ridx] = rd_data;
    rd_valid <= rd_req;
    rd_data  <= pat(rd_addr, salt);
    ridx     <= int'((rd_addr - run_base) >> 2);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rd_req) begin
    // R2 ascending addresses from the base
    chk(rd_addr === run_base + 32'(4 * nreq), "R2 addr", rd_addr, run_base + 32'(4 * nreq));
    nreq++;
  end

  task automatic run(input logic [31:0] b, input int len, input logic [31:0] s,
                     input int expw, input bit glitch, input bit midsel);
    int cyc;
    @(negedge clk);
    run_base = b; salt = s; nreq = 0;
    base_addr = b; byte_len = LEN_W'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start = glitch && (cyc == 3);
      if (start) begin base_addr = b + 32'h400; byte_len = LEN_W'(4); end
      if (midsel && cyc == 6) cpu_sel = 1'b1;
      if (midsel && cyc == 20) cpu_sel = 1'b0;
    end
    start = 1'b0;
    // R6 timing of done, R4 word count, R7 base/count kept
    chk(done === 1'b1, "R6 done seen", 32'(done), 1);
    chk(cyc == 2 * expw + 1, "R6 done cycle", 32'(cyc), 32'(2 * expw + 1));
    chk(nreq == expw, "R4 word count", 32'(nreq), 32'(expw));
    chk(busy === 1'b0, "R6 busy low at done", 32'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R6 done pulse", 32'(done), 0);
  endtask

  task automatic sweep();
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < OPDW; k++) begin
        logic [31:0] e;
        lk_sel = 2'(s); lk_idx = IDX_W'(k);
        @(negedge clk);
        // R9 stripe mapping, R3 stored words, R10 code 3 is zero
        e = (s == 3) ? 32'd0 : model[12 * (k / 4) + (k % 4) + 4 * s];
        chk(lk_data === e, (s == 3) ? "R10 lookup" : "R9/R3 lookup", lk_data, e);
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && rd_req === 1'b0, "R1 reset idle", {busy, done, rd_req}, 0);
    run(32'h1000_0000, IMG * 4, 32'h1111_0001, IMG, 0, 0);     // R1 full image
    sweep();
    run(32'h2000_0040, 13, 32'h2222_0002, 4, 0, 0);            // R4 round up
    sweep();
    run(32'h3000_0100, 1, 32'h3333_0003, 1, 0, 0);             // R4 single byte
    sweep();
    run(32'h4000_0000, 300, 32'h4444_0004, IMG, 0, 0);         // R4 clamp
    sweep();
    run(32'h5000_0000, 0, 32'h5555_0005, 0, 0, 0);             // R5 zero length
    run(32'h6000_0000, 40, 32'h6666_0006, 10, 1, 0);           // R7 start while busy
    sweep();
    run(32'h7000_0000, IMG * 4, 32'h7777_0007, IMG, 0, 1);     // R8 writes dropped under cpu_sel
    sweep();
    // R8 start ignored while cpu_sel is high
    @(negedge clk);
    cpu_sel = 1'b1; nreq = 0; byte_len = LEN_W'(64); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R8 start ignored", {done, busy}, 0);
    end
    chk(nreq == 0, "R8 no reads", 32'(nreq), 0);
    cpu_sel = 1'b0;
    sweep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule